// File: doc/BRIEF.md
# Double-Buffered Framebuffer Select Controller

This block decides which of two frame buffers the display shows and which one the processors may write. A frame-select bit in a display control register names the shown buffer. Write requests from the host and from the secondary processor are steered to the other, hidden buffer. Only the per-buffer write enables and the in-window address come out of the block; the write data goes to the buffer RAMs directly.

A new frame-select value takes effect at once when the display is blanked or switched off. Otherwise the value is parked as a pending request and lands on the next rising edge of vertical blank, so the shown picture never changes part-way through a frame. The block also holds the low byte of the mode/priority control register. When a write changes the priority bit, the block emits a one-cycle palette-dirty pulse.

Top module: `fbsel_top`

## Requirements
- R1: After reset the shown buffer is 0, no swap is pending, the control low byte is 0x00 and `palDirty` is low.
- R2: A write to offset 0xA while `vblank` is high sets the shown buffer to write-data bit 0 at that clock edge.
- R3: A write to offset 0xA while the mode field (control bits [1:0]) is zero applies at that edge even with `vblank` low.
- R4: A write to offset 0xA while `vblank` is low and the mode field is non-zero leaves the shown buffer unchanged and records a pending request.
- R5: A pending request is applied at the first clock edge that samples `vblank` high after it was low, and it then clears. Later vertical blanks do not change the buffer again.
- R6: `hostFbWe` and `cpuFbWe` are one-hot on the buffer that is not shown when their enable is high and zero otherwise. The buffer index is the bit position. Each address output is the low 17 bits of its bus address.
- R7: A read of offset 0xA returns the shown buffer in bit 0 and live `vblank` in bit 15, with all other bits zero.
- R8: A write to offset 0x0 stores only data bits [7:0]. A read of offset 0x0 returns that byte in [7:0], `palStatus` in bit 13, and zeros elsewhere.
- R9: `palDirty` is high for exactly the cycle after an offset-0x0 write that changes bit 7, and stays low after one that does not.
- R10: A write to any offset other than 0x0 and 0xA changes neither register nor the shown buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Register byte offset for read and write |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Combinational read data for `regAddr` |
| vblank | input | 1 | Live vertical-blank status |
| palStatus | input | 1 | Read-only palette status bit |
| hostWrEn | input | 1 | Host frame-buffer write request |
| hostWrAddr | input | 32 | Host bus address |
| cpuWrEn | input | 1 | Secondary processor frame-buffer write request |
| cpuWrAddr | input | 32 | Secondary processor bus address |
| dispBuf | output | 1 | Index of the shown buffer |
| hostFbWe | output | 2 | Host write enable per buffer |
| hostFbAddr | output | 17 | Host address inside the buffer window |
| cpuFbWe | output | 2 | Processor write enable per buffer |
| cpuFbAddr | output | 17 | Processor address inside the buffer window |
| palDirty | output | 1 | One-cycle palette-dirty pulse |

## Verification
Register state changes (frame select, pending request, control byte) and `palDirty` appear at the same edge that samples the write or the vertical-blank rise, one register stage. Read data and write steering are combinational on the current state. The bench drives every stimulus 1 ns after a rising edge. It samples registered results 1 ns after the next rising edge and samples combinational results after a 1 ns settle in the same cycle. Deferred swaps are checked over several active-display cycles before the blank edge, and again after a second blank, to show the request is consumed exactly once.

// File: rtl/fbsel_pkg.sv
package fbsel_pkg;
  typedef struct packed {
    logic fsNow;    // frame-select write applied this edge
    logic fsDefer;  // frame-select write parked until blank
    logic vblRise;  // first cycle of vertical blank
    logic ctrlWr;   // control register write
  } fbStrobe_t;
endpackage

// File: rtl/fbsel_ctrl.sv
module fbsel_ctrl
  import fbsel_pkg::*;
#(
  parameter int REG_ADDR_W = 4,
  parameter int MODE_W = 2,
  parameter logic [REG_ADDR_W-1:0] CTRL_OFS = 4'h0,
  parameter logic [REG_ADDR_W-1:0] FS_OFS = 4'hA
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  vblank,
  input  logic [MODE_W-1:0]     modeBits,
  output fbStrobe_t             strobe
);
  logic vblankQ;
  logic fsWr;
  logic displayIdle;

  always_ff @(posedge clk) begin
    if (!rstN) vblankQ <= 1'b0;
    else       vblankQ <= vblank;
  end

  always_comb begin
    fsWr           = regWrEn && (regAddr == FS_OFS);
    displayIdle    = vblank || (modeBits == '0);
    strobe.fsNow   = fsWr && displayIdle;
    strobe.fsDefer = fsWr && !displayIdle;
    strobe.vblRise = vblank && !vblankQ;
    strobe.ctrlWr  = regWrEn && (regAddr == CTRL_OFS);
  end

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.vblRise |=> !strobe.vblRise); // R5
endmodule

// File: rtl/fbsel_dp.sv
module fbsel_dp
  import fbsel_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_ADDR_W = 4,
  parameter int BUS_ADDR_W = 32,
  parameter int FB_ADDR_W = 17,
  parameter int MODE_W = 2,
  parameter int CTRL_W = 8,
  parameter int PRI_BIT = 7,
  parameter int PAL_STAT_BIT = 13,
  parameter int VBLK_BIT = 15,
  parameter int FS_BIT = 0,
  parameter logic [REG_ADDR_W-1:0] CTRL_OFS = 4'h0,
  parameter logic [REG_ADDR_W-1:0] FS_OFS = 4'hA
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  fbStrobe_t             strobe,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic                  vblank,
  input  logic                  palStatus,
  input  logic                  hostWrEn,
  input  logic [BUS_ADDR_W-1:0] hostWrAddr,
  input  logic                  cpuWrEn,
  input  logic [BUS_ADDR_W-1:0] cpuWrAddr,
  output logic [MODE_W-1:0]     modeBits,
  output logic                  dispBuf,
  output logic [1:0]            hostFbWe,
  output logic [FB_ADDR_W-1:0]  hostFbAddr,
  output logic [1:0]            cpuFbWe,
  output logic [FB_ADDR_W-1:0]  cpuFbAddr,
  output logic                  palDirty
);
  localparam int NUM_BUF = 2;

  logic [CTRL_W-1:0] ctrlLow;
  logic              fsCur;
  logic              fsPend;
  logic              pendVal;
  logic              palDirtyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlLow   <= '0;
      fsCur     <= 1'b0;
      fsPend    <= 1'b0;
      pendVal   <= 1'b0;
      palDirtyQ <= 1'b0;
    end else begin
      palDirtyQ <= strobe.ctrlWr && (regWrData[PRI_BIT] != ctrlLow[PRI_BIT]);
      if (strobe.ctrlWr) ctrlLow <= regWrData[CTRL_W-1:0];
      if (strobe.fsNow) begin
        fsCur  <= regWrData[FS_BIT];
        fsPend <= 1'b0;
      end else if (strobe.fsDefer) begin
        fsPend  <= 1'b1;
        pendVal <= regWrData[FS_BIT];
      end else if (strobe.vblRise && fsPend) begin
        fsCur  <= pendVal;
        fsPend <= 1'b0;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == CTRL_OFS) begin
      regRdData[CTRL_W-1:0]   = ctrlLow;
      regRdData[PAL_STAT_BIT] = palStatus;
    end else if (regAddr == FS_OFS) begin
      regRdData[FS_BIT]   = fsCur;
      regRdData[VBLK_BIT] = vblank;
    end
  end

  assign modeBits   = ctrlLow[MODE_W-1:0];
  assign dispBuf    = fsCur;
  assign palDirty   = palDirtyQ;
  assign hostFbAddr = hostWrAddr[FB_ADDR_W-1:0];
  assign cpuFbAddr  = cpuWrAddr[FB_ADDR_W-1:0];

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_steer
    localparam logic BIDX = 1'(b);
    assign hostFbWe[b] = hostWrEn && (fsCur != BIDX);
    assign cpuFbWe[b]  = cpuWrEn && (fsCur != BIDX);
  end

  AST_IMM_APPLY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fsNow |=> (fsCur == $past(regWrData[FS_BIT])) && !fsPend); // R2
  AST_DEFER_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fsDefer |=> fsPend); // R4
  AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.fsNow && !(strobe.vblRise && fsPend)) |=> $stable(fsCur)); // R4
  AST_PEND_APPLY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.vblRise && fsPend && !strobe.fsNow) |=> (fsCur == $past(pendVal)) && !fsPend); // R5
  AST_HIDDEN_HOST: assert property (@(posedge clk) disable iff (!rstN)
    hostWrEn |-> $onehot(hostFbWe) && !hostFbWe[fsCur]); // R6
  AST_HIDDEN_CPU: assert property (@(posedge clk) disable iff (!rstN)
    cpuWrEn |-> $onehot(cpuFbWe) && !cpuFbWe[fsCur]); // R6
  AST_PAL_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    palDirtyQ |-> $past(strobe.ctrlWr)); // R9
endmodule

// File: rtl/fbsel_top.sv
module fbsel_top
  import fbsel_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_ADDR_W = 4,
  parameter int BUS_ADDR_W = 32,
  parameter int FB_ADDR_W = 17,
  parameter int MODE_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic                  vblank,
  input  logic                  palStatus,
  input  logic                  hostWrEn,
  input  logic [BUS_ADDR_W-1:0] hostWrAddr,
  input  logic                  cpuWrEn,
  input  logic [BUS_ADDR_W-1:0] cpuWrAddr,
  output logic                  dispBuf,
  output logic [1:0]            hostFbWe,
  output logic [FB_ADDR_W-1:0]  hostFbAddr,
  output logic [1:0]            cpuFbWe,
  output logic [FB_ADDR_W-1:0]  cpuFbAddr,
  output logic                  palDirty
);
  localparam logic [REG_ADDR_W-1:0] CTRL_OFS = REG_ADDR_W'(4'h0);
  localparam logic [REG_ADDR_W-1:0] FS_OFS   = REG_ADDR_W'(4'hA);

  fbStrobe_t         strobe;
  logic [MODE_W-1:0] modeBits;

  fbsel_ctrl #(
    .REG_ADDR_W(REG_ADDR_W), .MODE_W(MODE_W),
    .CTRL_OFS(CTRL_OFS), .FS_OFS(FS_OFS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .vblank(vblank), .modeBits(modeBits), .strobe(strobe)
  );

  fbsel_dp #(
    .DATA_W(DATA_W), .REG_ADDR_W(REG_ADDR_W), .BUS_ADDR_W(BUS_ADDR_W),
    .FB_ADDR_W(FB_ADDR_W), .MODE_W(MODE_W),
    .CTRL_OFS(CTRL_OFS), .FS_OFS(FS_OFS)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .vblank(vblank),
    .palStatus(palStatus), .hostWrEn(hostWrEn), .hostWrAddr(hostWrAddr),
    .cpuWrEn(cpuWrEn), .cpuWrAddr(cpuWrAddr), .modeBits(modeBits),
    .dispBuf(dispBuf), .hostFbWe(hostFbWe), .hostFbAddr(hostFbAddr),
    .cpuFbWe(cpuFbWe), .cpuFbAddr(cpuFbAddr), .palDirty(palDirty)
  );
endmodule

// File: tb/tb_fbsel_top.sv
`timescale 1ns/1ps
module tb_fbsel_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        vblank = 1'b0;
  logic        palStatus = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [31:0] hostWrAddr = '0;
  logic        cpuWrEn = 1'b0;
  logic [31:0] cpuWrAddr = '0;
  logic        dispBuf;
  logic [1:0]  hostFbWe;
  logic [16:0] hostFbAddr;
  logic [1:0]  cpuFbWe;
  logic [16:0] cpuFbAddr;
  logic        palDirty;

  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  fbsel_top dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [15:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [15:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic testReset();
    logic [15:0] rd;
    check("R1 dispBuf", dispBuf, 0);
    check("R1 palDirty", palDirty, 0);
    regRead(4'h0, rd); check("R1 ctrl read", rd, 16'h0000);
    regRead(4'hA, rd); check("R1 fs read", rd, 16'h0000);
  endtask

  task automatic testModeOff();
    regWrite(4'hA, 16'h0001);
    check("R3 mode off immediate", dispBuf, 1);
    regWrite(4'hA, 16'h0000);
    check("R3 mode off back", dispBuf, 0);
  endtask

  task automatic testCtrl();
    logic [15:0] rd;
    palStatus = 1'b1;
    regWrite(4'h0, 16'hFF03);
    check("R9 no pri change", palDirty, 0);
    regRead(4'h0, rd); check("R8 low byte and status", rd, 16'h2003);
    regWrite(4'h0, 16'h0083);
    check("R9 pri change pulse", palDirty, 1);
    tick();
    check("R9 pulse one cycle", palDirty, 0);
    regWrite(4'h0, 16'h0083);
    check("R9 same pri no pulse", palDirty, 0);
    palStatus = 1'b0;
    regRead(4'h0, rd); check("R8 status live", rd, 16'h0083);
  endtask

  task automatic testDefer();
    logic [15:0] rd;
    vblank = 1'b0;
    regWrite(4'hA, 16'h0001);
    check("R4 deferred", dispBuf, 0);
    repeat (4) tick();
    check("R4 still deferred", dispBuf, 0);
    regRead(4'hA, rd); check("R7 read active fs0", rd, 16'h0000);
    vblank = 1'b1;
    tick();
    check("R5 applied at blank", dispBuf, 1);
    regRead(4'hA, rd); check("R7 read blank fs1", rd, 16'h8001);
    repeat (3) tick();
    vblank = 1'b0;
    repeat (3) tick();
    vblank = 1'b1;
    tick();
    check("R5 consumed once", dispBuf, 1);
  endtask

  task automatic testBlankWrite();
    logic [15:0] rd;
    regWrite(4'hA, 16'hFFFE);
    check("R2 blank immediate", dispBuf, 0);
    regRead(4'hA, rd); check("R7 read blank fs0", rd, 16'h8000);
    vblank = 1'b0;
    regWrite(4'hA, 16'h0001);
    vblank = 1'b1;
    tick();
    vblank = 1'b0;
    regRead(4'hA, rd); check("R7 read active fs1", rd, 16'h0001);
  endtask

  task automatic testSteer();
    hostWrEn = 1'b1; hostWrAddr = 32'h0403_ABCD;
    cpuWrEn = 1'b1;  cpuWrAddr = 32'h2400_1234;
    #1;
    check("R6 host we fs1", hostFbWe, 2'b01);
    check("R6 cpu we fs1", cpuFbWe, 2'b01);
    check("R6 host addr", hostFbAddr, 17'h1ABCD);
    check("R6 cpu addr", cpuFbAddr, 17'h01234);
    hostWrEn = 1'b0; cpuWrEn = 1'b0;
    vblank = 1'b1;
    regWrite(4'hA, 16'h0000);
    vblank = 1'b0;
    hostWrEn = 1'b1; cpuWrEn = 1'b1;
    #1;
    check("R6 host we fs0", hostFbWe, 2'b10);
    check("R6 cpu we fs0", cpuFbWe, 2'b10);
    hostWrEn = 1'b0; cpuWrEn = 1'b0;
    #1;
    check("R6 idle host we", hostFbWe, 2'b00);
    check("R6 idle cpu we", cpuFbWe, 2'b00);
  endtask

  task automatic testOtherOfs();
    logic [15:0] rd;
    regWrite(4'h4, 16'hFFFF);
    regWrite(4'h2, 16'hFFFF);
    check("R10 dispBuf unchanged", dispBuf, 0);
    check("R10 no pulse", palDirty, 0);
    regRead(4'h0, rd); check("R10 ctrl unchanged", rd, 16'h0083);
    regRead(4'hA, rd); check("R10 fs unchanged", rd, 16'h0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testModeOff();
    testCtrl();
    testDefer();
    testBlankWrite();
    testSteer();
    testOtherOfs();
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #1000000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule